// File: doc/BRIEF.md
# PLL Divider Configuration Controller

This block keeps the divider setting of a clock synthesizer's PLL in two places. One is the active configuration that drives the dividers: a 10-bit feedback divider M, a 3-bit output divider NA, a single-bit divider N and a single-bit pre-divider P. The other is a pair of staging bytes, a low byte and a high byte, that a serial register interface writes and reads back. A write port delivers single-byte writes. Two addresses reach the staging bytes. A third address is a write-only command register that moves data between the staging bytes and the active configuration, or nudges M up or down.

A GET command copies the active setting into the staging bytes. A LOAD command copies the staging bytes into the active setting. INC and DEC change M directly and leave the staging bytes alone, so software sees a stale copy until it issues a GET. While the active-low master reset is held low, the active setting follows the parallel configuration pins. The value on those pins in the last low cycle is therefore the setting the block keeps when reset is released. During that time the staging bytes stay at zero and every write is dropped.

Top module: `pll_div_cfg_ctrl`

## Requirements
- R1: While `mr_n` is low, `stg_lo` and `stg_hi` read 0 one cycle later, and no write or command alters them.
- R2: While `mr_n` is low, the active outputs take the pin values one cycle later. After `mr_n` goes high they keep the value captured in the last low cycle, and later pin changes have no effect.
- R3: A write to address 0x00 stores the data in `stg_lo`. A write to 0x01 stores data bits 6..0 in `stg_hi` and forces bit 7 to 0. Neither write changes the active outputs.
- R4: Staging layout: low byte = M[7:0]; high byte bits 1..0 = M[9:8], bits 4..2 = NA, bit 5 = N, bit 6 = P, bit 7 = 0.
- R5: Writing 0x02 to address 0xF0 (GET) copies the active setting into both staging bytes, using the R4 layout. The active setting is unchanged.
- R6: Writing 0x01 to address 0xF0 (LOAD) copies both staging bytes into the active setting, using the R4 layout. The staging bytes are unchanged.
- R7: Writing 0x03 (INC) or 0x04 (DEC) to address 0xF0 adds or subtracts one from the active M. NA, N, P and both staging bytes are unchanged.
- R8: INC with M = 1023 leaves M at 1023. DEC with M = 0 leaves M at 0.
- R9: Command values other than 0x01 to 0x04, and writes to any address other than 0x00, 0x01 and 0xF0, change no output.
- R10: Every write takes effect on the clock edge that samples it and is visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| mr_n | input | 1 | Active-low master reset, sampled synchronously |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| pin_m | input | 10 | Parallel initial M |
| pin_na | input | 3 | Parallel initial NA |
| pin_n | input | 1 | Parallel initial N |
| pin_p | input | 1 | Parallel initial P |
| act_m | output | 10 | Active M divider |
| act_na | output | 3 | Active NA divider |
| act_n | output | 1 | Active N divider |
| act_p | output | 1 | Active P divider |
| stg_lo | output | 8 | Staging low byte, for readback |
| stg_hi | output | 8 | Staging high byte, for readback |

## Verification
The assertions check several rules on every cycle:
- the command strobes are mutually exclusive;
- the staging bytes clear while reset is low;
- a staging write is stored;
- GET and LOAD copy the correct field layout;
- saturation holds at both ends of M;
- the active setting stays put when no command arrives.

Other behaviour needs the bench's scenarios. These cover the value captured when reset is released, a staging copy going stale after INC and DEC, ignored command codes and addresses, and long LOAD, INC and DEC sequences across the full range of M.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int M_W    = 10;
  localparam int NA_W   = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [M_W-1:0]  m;
    logic [NA_W-1:0] na;
    logic            n;
    logic            p;
  } div_cfg_t;

  function automatic logic [BYTE_W-1:0] pack_lo(div_cfg_t c);
    return c.m[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(div_cfg_t c);
    return {1'b0, c.p, c.n, c.na, c.m[M_W-1:BYTE_W]};
  endfunction

  function automatic div_cfg_t unpack(logic [BYTE_W-1:0] lo, logic [BYTE_W-1:0] hi);
    div_cfg_t c;
    c.m  = {hi[1:0], lo};
    c.na = hi[4:2];
    c.n  = hi[5];
    c.p  = hi[6];
    return c;
  endfunction
endpackage

// File: rtl/pdc_wr_decode.sv
module pdc_wr_decode #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter [ADDR_W-1:0] A_LO     = 8'h00,
  parameter [ADDR_W-1:0] A_HI     = 8'h01,
  parameter [ADDR_W-1:0] A_CMD    = 8'hF0,
  parameter [DATA_W-1:0] C_LOAD   = 8'h01,
  parameter [DATA_W-1:0] C_GET    = 8'h02,
  parameter [DATA_W-1:0] C_INC    = 8'h03,
  parameter [DATA_W-1:0] C_DEC    = 8'h04
) (
  input  logic              clk,
  input  logic              mr_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              do_load,
  output logic              do_get,
  output logic              do_inc,
  output logic              do_dec
);
  logic live, cmd;

  always_comb begin
    live    = wr_en && mr_n;
    cmd     = live && (wr_addr == A_CMD);
    wr_lo   = live && (wr_addr == A_LO);
    wr_hi   = live && (wr_addr == A_HI);
    do_load = cmd && (wr_data == C_LOAD);
    do_get  = cmd && (wr_data == C_GET);
    do_inc  = cmd && (wr_data == C_INC);
    do_dec  = cmd && (wr_data == C_DEC);
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk)
    $onehot0({wr_lo, wr_hi, do_load, do_get, do_inc, do_dec}));
endmodule

// File: rtl/pdc_stage.sv
module pdc_stage
  import pdc_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              mr_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              do_get,
  input  logic [DATA_W-1:0] wdata,
  input  div_cfg_t          act,
  output logic [DATA_W-1:0] stg_lo,
  output logic [DATA_W-1:0] stg_hi
);
  always_ff @(posedge clk) begin
    if (!mr_n) begin
      stg_lo <= '0;
      stg_hi <= '0;
    end else if (do_get) begin
      stg_lo <= pack_lo(act);
      stg_hi <= pack_hi(act);
    end else begin
      if (wr_lo) stg_lo <= wdata;
      if (wr_hi) stg_hi <= {1'b0, wdata[DATA_W-2:0]};
    end
  end

  // R1
  stage_clear_chk: assert property (@(posedge clk)
    !mr_n |=> (stg_lo == '0 && stg_hi == '0));
  // R3
  stage_hi_store_chk: assert property (@(posedge clk) disable iff (!mr_n)
    wr_hi |=> (stg_hi == {1'b0, $past(wdata[DATA_W-2:0])}));
  // R5
  stage_get_chk: assert property (@(posedge clk) disable iff (!mr_n)
    do_get |=> (stg_lo == pack_lo($past(act)) && stg_hi == pack_hi($past(act))));
endmodule

// File: rtl/pdc_active.sv
module pdc_active
  import pdc_pkg::*;
#(
  parameter int DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              mr_n,
  input  div_cfg_t          pins,
  input  logic              do_load,
  input  logic              do_inc,
  input  logic              do_dec,
  input  logic [DATA_W-1:0] stg_lo,
  input  logic [DATA_W-1:0] stg_hi,
  output div_cfg_t          cfg
);
  localparam logic [M_W-1:0] M_MAX = '1;
  localparam logic [M_W-1:0] M_ONE = {{(M_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!mr_n)        cfg <= pins;
    else if (do_load) cfg <= unpack(stg_lo, stg_hi);
    else if (do_inc)  cfg.m <= (cfg.m == M_MAX) ? cfg.m : cfg.m + M_ONE;
    else if (do_dec)  cfg.m <= (cfg.m == '0) ? cfg.m : cfg.m - M_ONE;
  end

  // R6
  active_load_chk: assert property (@(posedge clk) disable iff (!mr_n)
    do_load |=> (cfg == unpack($past(stg_lo), $past(stg_hi))));
  // R8
  inc_sat_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (do_inc && cfg.m == M_MAX) |=> (cfg.m == M_MAX));
  // R8
  dec_sat_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (do_dec && cfg.m == '0) |=> (cfg.m == '0));
  // R2
  active_hold_chk: assert property (@(posedge clk) disable iff (!mr_n)
    (!do_load && !do_inc && !do_dec) |=> $stable(cfg));
endmodule

// File: rtl/pll_div_cfg_ctrl.sv
module pll_div_cfg_ctrl
  import pdc_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter [ADDR_W-1:0] A_LO   = 8'h00,
  parameter [ADDR_W-1:0] A_HI   = 8'h01,
  parameter [ADDR_W-1:0] A_CMD  = 8'hF0
) (
  input  logic              clk,
  input  logic              mr_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [M_W-1:0]    pin_m,
  input  logic [NA_W-1:0]   pin_na,
  input  logic              pin_n,
  input  logic              pin_p,
  output logic [M_W-1:0]    act_m,
  output logic [NA_W-1:0]   act_na,
  output logic              act_n,
  output logic              act_p,
  output logic [BYTE_W-1:0] stg_lo,
  output logic [BYTE_W-1:0] stg_hi
);
  logic     wr_lo, wr_hi, do_load, do_get, do_inc, do_dec;
  div_cfg_t cfg, pins;

  assign pins = '{m: pin_m, na: pin_na, n: pin_n, p: pin_p};

  pdc_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W),
    .A_LO(A_LO), .A_HI(A_HI), .A_CMD(A_CMD)
  ) u_dec (
    .clk(clk), .mr_n(mr_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .do_load(do_load), .do_get(do_get),
    .do_inc(do_inc), .do_dec(do_dec)
  );

  pdc_stage #(.DATA_W(BYTE_W)) u_stage (
    .clk(clk), .mr_n(mr_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .do_get(do_get),
    .wdata(wr_data), .act(cfg), .stg_lo(stg_lo), .stg_hi(stg_hi)
  );

  pdc_active #(.DATA_W(BYTE_W)) u_act (
    .clk(clk), .mr_n(mr_n), .pins(pins), .do_load(do_load), .do_inc(do_inc),
    .do_dec(do_dec), .stg_lo(stg_lo), .stg_hi(stg_hi), .cfg(cfg)
  );

  assign act_m  = cfg.m;
  assign act_na = cfg.na;
  assign act_n  = cfg.n;
  assign act_p  = cfg.p;
endmodule

// File: tb/test_pll_div_cfg_ctrl.sv
module test_pll_div_cfg_ctrl;
  logic       clk = 1'b0;
  logic       mr_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [9:0] pin_m = 10'd500;
  logic [2:0] pin_na = 3'd2;
  logic       pin_n = 1'b0, pin_p = 1'b1;
  logic [9:0] act_m;
  logic [2:0] act_na;
  logic       act_n, act_p;
  logic [7:0] stg_lo, stg_hi;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  pll_div_cfg_ctrl i_pll_div_cfg_ctrl (
    .clk(clk), .mr_n(mr_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_m(pin_m), .pin_na(pin_na), .pin_n(pin_n), .pin_p(pin_p),
    .act_m(act_m), .act_na(act_na), .act_n(act_n), .act_p(act_p),
    .stg_lo(stg_lo), .stg_hi(stg_hi)
  );

  // vector: addr, data, exp m, na, n, p, stg_lo, stg_hi
  localparam logic [46:0] VEC [0:18] = '{
    {8'hF0, 8'h02, 10'd500,  3'd2, 1'b0, 1'b1, 8'hF4, 8'h49}, // R5 R4 GET
    {8'h00, 8'h10, 10'd500,  3'd2, 1'b0, 1'b1, 8'h10, 8'h49}, // R3 low write
    {8'h01, 8'hA6, 10'd500,  3'd2, 1'b0, 1'b1, 8'h10, 8'h26}, // R3 bit7 forced 0
    {8'hF0, 8'h01, 10'd528,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R6 LOAD
    {8'hF0, 8'h03, 10'd529,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R7 INC
    {8'hF0, 8'h04, 10'd528,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R7 DEC
    {8'hF0, 8'h04, 10'd527,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R7 DEC
    {8'hF0, 8'h07, 10'd527,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R9 bad code
    {8'h05, 8'hFF, 10'd527,  3'd1, 1'b1, 1'b0, 8'h10, 8'h26}, // R9 bad addr
    {8'hF0, 8'h02, 10'd527,  3'd1, 1'b1, 1'b0, 8'h0F, 8'h26}, // R5 GET
    {8'h00, 8'hFF, 10'd527,  3'd1, 1'b1, 1'b0, 8'hFF, 8'h26}, // R3
    {8'h01, 8'h03, 10'd527,  3'd1, 1'b1, 1'b0, 8'hFF, 8'h03}, // R3
    {8'hF0, 8'h01, 10'd1023, 3'd0, 1'b0, 1'b0, 8'hFF, 8'h03}, // R6 LOAD max
    {8'hF0, 8'h03, 10'd1023, 3'd0, 1'b0, 1'b0, 8'hFF, 8'h03}, // R8 INC sat
    {8'h00, 8'h00, 10'd1023, 3'd0, 1'b0, 1'b0, 8'h00, 8'h03}, // R3
    {8'h01, 8'h00, 10'd1023, 3'd0, 1'b0, 1'b0, 8'h00, 8'h00}, // R3
    {8'hF0, 8'h01, 10'd0,    3'd0, 1'b0, 1'b0, 8'h00, 8'h00}, // R6 LOAD zero
    {8'hF0, 8'h04, 10'd0,    3'd0, 1'b0, 1'b0, 8'h00, 8'h00}, // R8 DEC sat
    {8'hF0, 8'h03, 10'd1,    3'd0, 1'b0, 1'b0, 8'h00, 8'h00}  // R7 R10 INC
  };

  task automatic chk(string tag, logic [30:0] got, logic [30:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [30:0] outs();
    return {act_m, act_na, act_n, act_p, stg_lo, stg_hi};
  endfunction

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 R2: reset state follows pins, staging zero
    chk("R1 R2 reset state", outs(), {10'd500, 3'd2, 1'b0, 1'b1, 8'h00, 8'h00});
    // R1: writes during reset are dropped
    wr(8'h00, 8'h55);
    wr(8'hF0, 8'h02);
    chk("R1 write in reset", outs(), {10'd500, 3'd2, 1'b0, 1'b1, 8'h00, 8'h00});
    @(negedge clk) mr_n = 1'b1;
    @(negedge clk) begin pin_m = 10'd77; pin_na = 3'd5; pin_n = 1'b1; pin_p = 1'b0; end
    repeat (2) @(negedge clk);
    chk("R2 pins ignored after release", outs(), {10'd500, 3'd2, 1'b0, 1'b1, 8'h00, 8'h00});

    for (int i = 0; i < 19; i++) begin
      wr(VEC[i][46:39], VEC[i][38:31]);
      chk($sformatf("vector %0d R4 R10", i), outs(), VEC[i][30:0]);
    end

    // R2: new capture on a second reset, last low cycle wins
    @(negedge clk) mr_n = 1'b0;
    @(negedge clk) begin pin_m = 10'd5; pin_na = 3'd7; pin_n = 1'b1; pin_p = 1'b0; end
    @(negedge clk) mr_n = 1'b1;
    @(negedge clk) pin_m = 10'd900;
    @(negedge clk);
    chk("R2 recapture", outs(), {10'd5, 3'd7, 1'b1, 1'b0, 8'h00, 8'h00});
    // R5 R4: GET after recapture
    wr(8'hF0, 8'h02);
    chk("R5 GET layout", outs(), {10'd5, 3'd7, 1'b1, 1'b0, 8'h05, 8'h3C});
    // R7: INC leaves staging stale
    wr(8'hF0, 8'h03);
    chk("R7 stale staging", outs(), {10'd6, 3'd7, 1'b1, 1'b0, 8'h05, 8'h3C});
    // R9: code 0x00 ignored
    wr(8'hF0, 8'h00);
    chk("R9 code zero", outs(), {10'd6, 3'd7, 1'b1, 1'b0, 8'h05, 8'h3C});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule